// File: doc/BRIEF.md
# Two-Share Masked Key Store

This block keeps a cipher key as two separate 256-bit halves. Each half is eight 32-bit words, and the usable key is the word-by-word XOR of the two. Software loads the halves one word at a time through a plain write port. Each word is addressed by a 4-bit index: the top bit picks the half and the low three bits pick the word. The block tracks which of the sixteen locations have received a write. It raises a valid flag only once every location has been written at least once. This applies whatever key length is selected, and the words may arrive in any order.

A length select chooses 128-, 192- or 256-bit keys. Word positions above the selected length still have to be written, but they show as zero in the combined key output. While the surrounding unit reports that it is not idle, incoming writes are discarded.

A clear request wipes all sixteen locations with words taken from an internal 32-bit LFSR, one location per cycle, and withdraws every written flag. After a clear, software has to load the whole key again.

Top module: `masked_key_bank`

## Requirements
- R1: After reset, `keyOut` is zero, `keyValid` is 0 and `wordWritten` is all zeros.
- R2: `wrAddr[3]` selects the half (0 = first, 1 = second) and `wrAddr[2:0]` selects the word. Key word i appears at `keyOut[32*i+31:32*i]`, so word 0 holds the least-significant bits.
- R3: Each active word of `keyOut` equals the first-half word XOR the second-half word at the same word index.
- R4: `keyLen` 2'b00 enables words 0-3, 2'b01 enables words 0-5, and 2'b10 or 2'b11 enables words 0-7. Words outside the enabled range read as zero on `keyOut`.
- R5: An accepted write sets bit `wrAddr` of `wordWritten` one cycle later. Bits are never cleared by writes. `keyValid` is 1 only while all 16 bits are set, whatever the write order and whatever the key length.
- R6: A write made while `idle` is 0 changes no stored word and sets no flag.
- R7: A clear request raised while no clear is running starts a sequence on the next edge. That edge zeroes `wordWritten`. The 16 edges that follow load locations 0 through 15 in index order. Each location takes the current LFSR state, and the LFSR then advances. The LFSR shifts right in Galois form with feedback mask 32'h80200003.
- R8: Writes presented while a clear runs, or in the same cycle as the clear request, are discarded. `wordWritten` stays zero until the sequence ends.
- R9: The LFSR is loaded with 32'h1F2E3D4C at reset and only advances during clears, so a second clear continues the sequence where the first one stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Location index: half select in bit 3, word in bits 2:0 |
| wrData | input | 32 | Write data |
| idle | input | 1 | High when the unit accepts key writes |
| keyLen | input | 2 | Key length select |
| clearReq | input | 1 | Request to wipe the store with pseudo-random words |
| keyOut | output | 256 | Combined key, masked to the selected length |
| keyValid | output | 1 | All 16 locations written since the last reset or clear |
| wordWritten | output | 16 | Per-location written flags |

## Verification
The halves are loaded in a scrambled order with unrelated random-looking data. Each output word then has to match the XOR of its own two locations, which exposes swapped halves, swapped word slots and a plain copy of one half. The same stored key is read under all three length codes to separate the masking boundaries at four, six and eight words. Busy-time writes and writes made during or alongside a clear are aimed at locations whose content or flag would visibly change. Two clears in a row are compared against an independently stepped LFSR model, which shows whether the generator continues across sequences or restarts.

// File: rtl/keybank_pkg.sv
package keybank_pkg;
  parameter int WORD_W     = 32;
  parameter int NUM_WORDS  = 8;
  parameter int NUM_SHARES = 2;

  localparam int TOTAL_WORDS = NUM_WORDS * NUM_SHARES;
  localparam int IDX_W       = $clog2(TOTAL_WORDS);
  localparam int WSEL_W      = $clog2(NUM_WORDS);
  localparam int KEY_W       = WORD_W * NUM_WORDS;
  localparam int WORDS_128   = 128 / WORD_W;
  localparam int WORDS_192   = 192 / WORD_W;

  typedef enum logic [1:0] {
    LEN_128 = 2'b00,
    LEN_192 = 2'b01,
    LEN_256 = 2'b10
  } keyLen_e;

  typedef enum logic {
    ST_READY,
    ST_WIPE
  } ctrlState_e;

  typedef struct packed {
    logic             load;
    logic             fromLfsr;
    logic [IDX_W-1:0] idx;
    logic             advance;
  } bankStrobe_t;
endpackage

// File: rtl/keybank_ctrl.sv
module keybank_ctrl
  import keybank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrAddr,
  input  logic                   idle,
  input  logic                   clearReq,
  output bankStrobe_t            strobe,
  output logic [TOTAL_WORDS-1:0] written,
  output logic                   keyValid,
  output logic                   clearing
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);

  ctrlState_e       state;
  logic [IDX_W-1:0] wipeIdx;
  logic             acceptWr;

  assign acceptWr = wrEn && idle && (state == ST_READY) && !clearReq;
  assign clearing = (state == ST_WIPE);
  assign keyValid = &written;

  always_comb begin
    strobe = '0;
    if (state == ST_WIPE) begin
      strobe.load     = 1'b1;
      strobe.fromLfsr = 1'b1;
      strobe.idx      = wipeIdx;
      strobe.advance  = 1'b1;
    end else if (acceptWr) begin
      strobe.load = 1'b1;
      strobe.idx  = wrAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_READY;
      wipeIdx <= '0;
      written <= '0;
    end else begin
      case (state)
        ST_READY: begin
          if (clearReq) begin
            state   <= ST_WIPE;
            wipeIdx <= '0;
            written <= '0;
          end else if (acceptWr) begin
            written[wrAddr] <= 1'b1;
          end
        end
        ST_WIPE: begin
          wipeIdx <= wipeIdx + 1'b1;
          if (wipeIdx == LAST_IDX) state <= ST_READY;
        end
        default: state <= ST_READY;
      endcase
    end
  end
endmodule

// File: rtl/keybank_datapath.sv
module keybank_datapath
  import keybank_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 32'h1F2E3D4C,
  parameter logic [WORD_W-1:0] TAPS = 32'h80200003
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        keyLen,
  output logic [KEY_W-1:0]  keyOut
);
  logic [WORD_W-1:0] bank [TOTAL_WORDS];
  logic [WORD_W-1:0] lfsr;
  logic [WSEL_W:0]   activeWords;

  function automatic logic [WORD_W-1:0] stepLfsr(input logic [WORD_W-1:0] s);
    return {1'b0, s[WORD_W-1:1]} ^ (s[0] ? TAPS : '0);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL_WORDS; i++) bank[i] <= '0;
      lfsr <= SEED;
    end else begin
      if (strobe.load) bank[strobe.idx] <= strobe.fromLfsr ? lfsr : wrData;
      if (strobe.advance) lfsr <= stepLfsr(lfsr);
    end
  end

  always_comb begin
    case (keyLen)
      LEN_128: activeWords = (WSEL_W+1)'(WORDS_128);
      LEN_192: activeWords = (WSEL_W+1)'(WORDS_192);
      default: activeWords = (WSEL_W+1)'(NUM_WORDS);
    endcase
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [WSEL_W:0] W_POS = (WSEL_W+1)'(w);
    assign keyOut[w*WORD_W +: WORD_W] =
      (W_POS < activeWords) ? (bank[w] ^ bank[NUM_WORDS + w]) : '0;
  end
endmodule

// File: rtl/masked_key_bank.sv
module masked_key_bank
  import keybank_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h1F2E3D4C
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic [31:0]   wrData,
  input  logic          idle,
  input  logic [1:0]    keyLen,
  input  logic          clearReq,
  output logic [255:0]  keyOut,
  output logic          keyValid,
  output logic [15:0]   wordWritten
);
  bankStrobe_t strobe;
  logic        clearing;

  keybank_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .idle     (idle),
    .clearReq (clearReq),
    .strobe   (strobe),
    .written  (wordWritten),
    .keyValid (keyValid),
    .clearing (clearing)
  );

  keybank_datapath #(.SEED(SEED)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .keyLen (keyLen),
    .keyOut (keyOut)
  );
endmodule

// File: rtl/masked_key_bank_chk.sv
module masked_key_bank_chk (
  input logic         clk,
  input logic         rstN,
  input logic         idle,
  input logic         clearReq,
  input logic         clearing,
  input logic [1:0]   keyLen,
  input logic [255:0] keyOut,
  input logic         keyValid,
  input logic [15:0]  wordWritten
);
  logic [4:0] wipeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wipeRun <= '0;
    else if (clearing) wipeRun <= wipeRun + 1'b1;
    else wipeRun <= '0;
  end

  p_valid_needs_all_r5: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> (wordWritten == 16'hFFFF));

  p_flags_only_grow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clearReq && !clearing) |=> ((wordWritten & $past(wordWritten)) == $past(wordWritten)));

  p_busy_no_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !clearReq && !clearing) |=> $stable(wordWritten));

  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !clearing) |=> (wordWritten == 16'h0000));

  p_wipe_holds_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearing |=> (wordWritten == 16'h0000));

  p_wipe_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clearing) |-> (wipeRun == 5'd16));

  p_wipe_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearing |-> (wipeRun < 5'd16));

  p_short_key_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyLen == 2'b00) |-> (keyOut[255:128] == '0));

  p_mid_key_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyLen == 2'b01) |-> (keyOut[255:192] == '0));
endmodule

bind masked_key_bank masked_key_bank_chk u_chk (.*);

// File: tb/masked_key_bank_test.sv
module masked_key_bank_test;
  localparam logic [31:0] SEED_V = 32'h1F2E3D4C;
  localparam logic [31:0] TAPS_V = 32'h80200003;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         idle = 1'b1;
  logic [1:0]   keyLen = 2'b10;
  logic         clearReq = 1'b0;
  logic [255:0] keyOut;
  logic         keyValid;
  logic [15:0]  wordWritten;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] m [16];
  logic [31:0] lfsrModel;

  masked_key_bank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .idle(idle), .keyLen(keyLen), .clearReq(clearReq),
    .keyOut(keyOut), .keyValid(keyValid), .wordWritten(wordWritten)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] stepModel(input logic [31:0] s);
    logic [31:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ TAPS_V;
    return r;
  endfunction

  function automatic logic [255:0] expKey(input logic [1:0] kl);
    logic [255:0] r;
    int n;
    r = '0;
    n = (kl == 2'b00) ? 4 : (kl == 2'b01) ? 6 : 8;
    for (int i = 0; i < n; i++) r[i*32 +: 32] = m[i] ^ m[8+i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic idleV);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; idle = idleV;
    @(negedge clk);
    wrEn = 1'b0; idle = 1'b1;
  endtask

  task automatic modelWipe();
    for (int k = 0; k < 16; k++) begin
      m[k] = lfsrModel;
      lfsrModel = stepModel(lfsrModel);
    end
  endtask

  task automatic t_reset();
    check(keyOut == '0, "R1 keyOut after reset", keyOut, '0);
    check(keyValid == 1'b0, "R1 keyValid after reset", 256'(keyValid), 256'(0));
    check(wordWritten == '0, "R1 flags after reset", 256'(wordWritten), 256'(0));
  endtask

  task automatic t_full_load();
    int order [16] = '{11, 2, 15, 0, 7, 9, 4, 13, 1, 14, 6, 8, 3, 12, 5, 10};
    logic [15:0] expFlags = '0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] d;
      d = 32'h9E3779B9 * (order[k] + 3) ^ 32'h5A5A0000;
      m[order[k]] = d;
      wr(4'(order[k]), d, 1'b1);
      expFlags[order[k]] = 1'b1;
      check(wordWritten == expFlags, "R5 flag per write", 256'(wordWritten), 256'(expFlags));
      if (k < 15) check(keyValid == 1'b0, "R5 not valid before all words", 256'(keyValid), 256'(0));
    end
    check(keyValid == 1'b1, "R5 valid after all 16 words", 256'(keyValid), 256'(1));
    check(keyOut == expKey(2'b10), "R2 R3 full key xor", keyOut, expKey(2'b10));
    m[3] = 32'hCAFEF00D;
    wr(4'd3, 32'hCAFEF00D, 1'b1);
    check(wordWritten == 16'hFFFF && keyValid, "R5 rewrite keeps flags", 256'(wordWritten), 256'(16'hFFFF));
    check(keyOut == expKey(2'b10), "R3 rewrite updates word", keyOut, expKey(2'b10));
  endtask

  task automatic t_lengths();
    for (int kl = 0; kl < 4; kl++) begin
      @(negedge clk);
      keyLen = 2'(kl);
      #1;
      check(keyOut == expKey(2'(kl)), "R4 length masking", keyOut, expKey(2'(kl)));
    end
    @(negedge clk);
    keyLen = 2'b10;
  endtask

  task automatic t_busy();
    wr(4'd9, 32'h0BADBEEF, 1'b0);
    check(keyOut == expKey(2'b10), "R6 busy write leaves key", keyOut, expKey(2'b10));
  endtask

  task automatic t_clear();
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
    modelWipe();
    repeat (4) @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd0; wrData = 32'h11112222;
    @(negedge clk); wrEn = 1'b0;
    repeat (16) @(negedge clk);
    check(wordWritten == '0, "R8 write during clear sets no flag", 256'(wordWritten), 256'(0));
    check(keyValid == 1'b0, "R7 clear drops valid", 256'(keyValid), 256'(0));
    check(keyOut == expKey(2'b10), "R7 R8 wipe content from lfsr", keyOut, expKey(2'b10));
    wr(4'd3, 32'h77778888, 1'b0);
    check(wordWritten == '0, "R6 busy write sets no flag", 256'(wordWritten), 256'(0));
    check(keyOut == expKey(2'b10), "R6 busy write after clear", keyOut, expKey(2'b10));
  endtask

  task automatic t_second_clear();
    wr(4'd4, 32'h12345678, 1'b1);
    check(wordWritten == 16'h0010, "R5 single flag after clear", 256'(wordWritten), 256'(16'h0010));
    @(negedge clk);
    clearReq = 1'b1; wrEn = 1'b1; wrAddr = 4'd6; wrData = 32'hFFFF0000;
    @(negedge clk);
    clearReq = 1'b0; wrEn = 1'b0;
    check(wordWritten == '0, "R8 write beside clear request", 256'(wordWritten), 256'(0));
    modelWipe();
    repeat (18) @(negedge clk);
    check(keyOut == expKey(2'b10), "R9 lfsr continues across clears", keyOut, expKey(2'b10));
  endtask

  task automatic t_reload();
    for (int k = 15; k >= 0; k--) begin
      m[k] = 32'hA5000000 | 32'(k * 257);
      wr(4'(k), m[k], 1'b1);
    end
    check(keyValid == 1'b1, "R5 valid after reload", 256'(keyValid), 256'(1));
    check(keyOut == expKey(2'b10), "R3 reload key", keyOut, expKey(2'b10));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    lfsrModel = SEED_V;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_load();
    t_lengths();
    t_busy();
    t_clear();
    t_second_clear();
    t_reload();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule